// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an asynchronous static RAM of 512K eight-bit words. The host hands over one request at a time: a read or a write of one word at a 19-bit address. The controller turns each request into a sequence of registered chip-select, write-strobe and read-strobe levels. It holds each level for a whole number of clock cycles. That number comes from the memory's nanosecond limits and the clock period.

Every limit is given in nanoseconds as a parameter and turned into cycles by rounding up, with a floor of one cycle. The shared data bus is split into an output value, a driver enable and an input value. The pad that joins them sits outside this block. During a write the read strobe stays high, so the memory never needs time to release the bus at the start of a write. After a read there is a recovery interval, so the memory has released the bus before the controller can drive it again. The host sees a ready signal, a one-cycle completion pulse and a read-data register that keeps its value until the next read.

With the default 10 ns clock the derived counts are as follows:
- read strobe window: 10 cycles
- write-strobe pulse: 8 cycles
- read-to-drive turnaround: 3 cycles
- minimum spacing between accesses: 10 cycles

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_done` is 0 and `rsp_rdata` is 0. These values take effect at once, even in the middle of an access.
- R2: `req_ready` is 1 only when no access is in progress. A request is taken at a rising edge where `req_valid` and `req_ready` are both 1, and its address and write data are captured at that edge. Later changes on the request inputs do not affect the access that was taken. While `req_ready` is 1, `mem_ce_n` is 1 and `mem_dq_oe` is 0.
- R3: A read (`req_write`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly N_RD = max(ceil(T_ACCESS/T), ceil(T_CYCLE/T)) cycles. N_RD is 10 at T=10 ns. The byte on `mem_dq_i` at the last edge of that window goes to `rsp_rdata`. `rsp_done` is seen N_RD+1 cycles after the accept edge.
- R4: A write (`req_write`=1) holds `mem_ce_n`=0, `mem_oe_n`=1 and `mem_we_n`=0 for exactly N_WR = max(ceil(T_WE_PULSE/T), ceil(T_ADDR_TO_END/T), ceil(T_DATA_SETUP/T)) cycles. N_WR is 8 at T=10 ns. The write data is driven on `mem_dq_o` with `mem_dq_oe`=1 from the first cycle of that window. Chip select and data are held for one more cycle after `mem_we_n` rises. `rsp_done` is seen N_WR+2 cycles after the accept edge.
- R5: `mem_dq_oe` is never 1 while the memory may drive the bus, that is, while `mem_ce_n` and `mem_oe_n` are both 0.
- R6: After `mem_oe_n` rises at the end of a read, `mem_dq_oe` stays 0 for at least N_TURN = ceil(T_OE_RELEASE/T) cycles. N_TURN is 3 at T=10 ns.
- R7: `mem_addr` does not change while `mem_ce_n` stays 0, and `mem_dq_o` does not change while `mem_dq_oe` stays 1.
- R8: Two falls of `mem_ce_n` are at least ceil(T_CYCLE/T) cycles apart. `mem_we_n` stays 1 for at least ceil(T_WE_GAP/T) cycles between two write pulses.
- R9: `rsp_done` is a one-cycle pulse, given once per access. `rsp_rdata` changes only when a read completes, so a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_rdata | output | DATA_W (8) | Last captured read data |
| rsp_done | output | 1 | One-cycle pulse at the end of each access |
| mem_addr | output | ADDR_W (19) | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_dq_o | output | DATA_W (8) | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data-bus driver |
| mem_dq_i | input | DATA_W (8) | Data returned from the memory bus |

## Verification
Reads are tried at every walking-one address and at the lowest and highest address. The bench memory model returns an address-derived byte only after the full access window; before that it returns a dummy byte. A read sampled even one cycle early, or taken from a wrong address bit, therefore shows up as a wrong byte.

Writes sweep all 256 data values at scattered addresses, and the request inputs are scrambled right after each accept. This separates a correct capture at the accept edge from one that follows the live inputs.

An alternating read/write run exercises the turnaround and spacing rules. A reset in the middle of an access checks that the strobes release at once and that the controller recovers afterwards.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RD    = 3'd1,
    S_WR    = 3'd2,
    S_WHOLD = 3'd3,
    S_REC   = 3'd4
  } seq_state_e;

  // Whole clock cycles that cover a nanosecond limit, never fewer than one.
  function automatic int ns2cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_ctr.sv
module sram_wait_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ld || (cnt_q != '0);
    cnt_d  = ld ? ld_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int N_RD   = 10,
  parameter int N_WR   = 8,
  parameter int N_RREC = 2,
  parameter int N_WREC = 1,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             zero,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             done_d,
  output logic             ld,
  output logic [CNT_W-1:0] ld_val,
  output seq_state_e       nxt
);

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(N_WR - 1);
  localparam logic [CNT_W-1:0] LD_RREC = CNT_W'(N_RREC - 1);
  localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(N_WREC - 1);

  seq_state_e state_q;

  always_comb begin
    nxt     = state_q;
    accept  = 1'b0;
    capture = 1'b0;
    done_d  = 1'b0;
    ld      = 1'b0;
    ld_val  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          ld     = 1'b1;
          if (req_write) begin
            nxt    = S_WR;
            ld_val = LD_WR;
          end else begin
            nxt    = S_RD;
            ld_val = LD_RD;
          end
        end
      end
      S_RD: begin
        if (zero) begin
          capture = 1'b1;
          done_d  = 1'b1;
          nxt     = S_REC;
          ld      = 1'b1;
          ld_val  = LD_RREC;
        end
      end
      S_WR: begin
        if (zero) nxt = S_WHOLD;
      end
      S_WHOLD: begin
        done_d = 1'b1;
        nxt    = S_REC;
        ld     = 1'b1;
        ld_val = LD_WREC;
      end
      S_REC: begin
        if (zero) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= nxt;
  end

  assign req_ready = (state_q == S_IDLE);

  // R2: once an access is under way, the host side is closed until recovery ends
  p_busy_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              done_d,
  input  seq_state_e        nxt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done
);

  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  // Strobe levels follow the state being entered, so they leave a flop cleanly.
  always_comb begin
    ce_n_d  = !((nxt == S_RD) || (nxt == S_WR) || (nxt == S_WHOLD));
    we_n_d  = !(nxt == S_WR);
    oe_n_d  = !(nxt == S_RD);
    dq_oe_d =  (nxt == S_WR) || (nxt == S_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_done  <= 1'b0;
    end else begin
      mem_ce_n  <= ce_n_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
      rsp_done  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      mem_dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rsp_rdata <= '0;
    else if (capture) rsp_rdata <= mem_dq_i;
  end

  // R5: the driver is only on when the memory output stage is off
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R3: a read strobe only appears with chip select and without write strobe
  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R4: a write strobe comes with chip select, driven data and read strobe high
  p_write_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  // R7: address holds across a selected interval
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R7: driven data holds while the driver stays on
  p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W           = 19,
  parameter int DATA_W           = 8,
  parameter int CLK_PERIOD_NS    = 10,
  parameter int T_ACCESS_NS      = 100,
  parameter int T_CYCLE_NS       = 100,
  parameter int T_WE_PULSE_NS    = 60,
  parameter int T_ADDR_TO_END_NS = 80,
  parameter int T_DATA_SETUP_NS  = 40,
  parameter int T_OE_RELEASE_NS  = 30,
  parameter int T_WE_GAP_NS      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int N_CYC  = ns2cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int N_RD   = imax(ns2cyc(T_ACCESS_NS, CLK_PERIOD_NS), N_CYC);
  localparam int N_WR   = imax(imax(ns2cyc(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                    ns2cyc(T_ADDR_TO_END_NS, CLK_PERIOD_NS)),
                               ns2cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int N_TURN = ns2cyc(T_OE_RELEASE_NS, CLK_PERIOD_NS);
  localparam int N_WGAP = ns2cyc(T_WE_GAP_NS, CLK_PERIOD_NS);
  // Recovery after a read: strobe rise to next drive is N_RREC+1 cycles.
  localparam int N_RREC = imax(1, N_TURN - 1);
  // Recovery after a write: covers both the cycle time and the strobe gap.
  localparam int N_WREC = imax(1, imax(N_CYC - N_WR - 2, N_WGAP - 2));
  localparam int N_MAX  = imax(imax(N_RD, N_WR), imax(N_RREC, N_WREC));
  localparam int CNT_W  = $clog2(N_MAX + 1);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             ctr_ld, ctr_zero;
  logic [CNT_W-1:0] ctr_ld_val;
  logic             accept, capture, done_d;
  seq_state_e       nxt;

  sram_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ld     (ctr_ld),
    .ld_val (ctr_ld_val),
    .zero   (ctr_zero)
  );

  sram_seq_fsm #(
    .N_RD   (N_RD),
    .N_WR   (N_WR),
    .N_RREC (N_RREC),
    .N_WREC (N_WREC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .zero      (ctr_zero),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .done_d    (done_d),
    .ld        (ctr_ld),
    .ld_val    (ctr_ld_val),
    .nxt       (nxt)
  );

  sram_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .capture   (capture),
    .done_d    (done_d),
    .nxt       (nxt),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .rsp_rdata (rsp_rdata),
    .rsp_done  (rsp_done)
  );

  // Checker counters for the timing windows.
  localparam int GAP_W = $clog2(N_TURN + 2);
  localparam int WL_W  = $clog2(N_WR + 2);

  logic [GAP_W-1:0] oe_gap_q;
  logic [WL_W-1:0]  we_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                oe_gap_q <= '1;
    else if (!mem_oe_n)        oe_gap_q <= '0;
    else if (oe_gap_q != '1)   oe_gap_q <= oe_gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                we_low_q <= '0;
    else if (mem_we_n)         we_low_q <= '0;
    else if (we_low_q != '1)   we_low_q <= we_low_q + 1'b1;
  end

  // R6: driver turns on only after the release time has passed
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_gap_q >= GAP_W'(N_TURN)));

  // R4: write strobe low for the whole derived pulse
  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_q >= WL_W'(N_WR)));

  // R2: an idle controller leaves the memory deselected and the bus free
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

endmodule

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;

  localparam int T      = 10;
  localparam int N_CYC  = (100 + T - 1) / T;
  localparam int N_RD   = N_CYC;
  localparam int N_WR   = (80 + T - 1) / T;
  localparam int N_TURN = (30 + T - 1) / T;
  localparam int N_WGAP = 1;
  localparam int LIMIT  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hEE;

  always #5 clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_checks = 0, n_errors = 0, cyc = 0;

  function automatic logic [7:0] pat(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Memory model and bus monitor, evaluated away from the active edge.
  int rd_run = 0, hold = 0, wl = 0, wgap = 0, last_wl = 0, wr_events = 0;
  int last_start = 0, min_gap = 1000000;
  bit started = 0, wr_seen = 0;
  int v_cont = 0, v_turn = 0, v_addr = 0, v_data = 0, v_wr = 0, v_gap = 0;
  logic [18:0] last_waddr = '0, addr_prev = '0;
  logic [7:0]  last_wdata = '0, dq_prev = '0;
  logic        ce_prev = 1'b1, we_prev = 1'b1, dqoe_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      rd_run = 0; hold = 0; wl = 0; wgap = 0; started = 0; wr_seen = 0;
      mem_dq_i = 8'hEE;
      ce_prev = 1'b1; we_prev = 1'b1; dqoe_prev = 1'b0;
    end else begin
      if (mem_dq_oe && !mem_ce_n && !mem_oe_n) v_cont++;
      if (mem_dq_oe && hold > 0) v_turn++;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        rd_run++; hold = N_TURN;
      end else begin
        rd_run = 0; if (hold > 0) hold--;
      end
      mem_dq_i = (rd_run >= N_RD) ? pat(mem_addr) : 8'hEE;
      if (!mem_ce_n && !ce_prev && mem_addr != addr_prev) v_addr++;
      if (mem_dq_oe && dqoe_prev && mem_dq_o != dq_prev) v_data++;
      if (!mem_we_n) begin
        if (mem_ce_n || !mem_oe_n || !mem_dq_oe) v_wr++;
        if (we_prev) begin
          if (wr_seen && wgap < N_WGAP) v_gap++;
        end
        wl++; wgap = 0;
      end else begin
        if (!we_prev) begin
          last_wl = wl; last_wdata = dq_prev; last_waddr = addr_prev;
          wr_events++; wr_seen = 1;
        end
        wl = 0; wgap++;
      end
      if (!mem_ce_n && ce_prev) begin
        if (started && (cyc - last_start) < min_gap) min_gap = cyc - last_start;
        started = 1; last_start = cyc;
      end
      ce_prev = mem_ce_n; we_prev = mem_we_n; dqoe_prev = mem_dq_oe;
      addr_prev = mem_addr; dq_prev = mem_dq_o;
    end
  end

  // One access through the host port; returns cycles from accept to done.
  task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                       output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
    chk(!req_ready, "R2 busy", req_ready, 0);
    lat = 1;
    while (!rsp_done && lat < 200) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic rd_chk(input logic [18:0] a, input string tag);
    int lat;
    do_op(1'b0, a, 8'h00, lat);
    chk(rsp_rdata == pat(a), {"R3 data ", tag}, rsp_rdata, pat(a));
    chk(lat == N_RD + 1, "R3 latency", lat, N_RD + 1);
    @(negedge clk);
    chk(!rsp_done, "R9 pulse", rsp_done, 0);
  endtask

  task automatic wr_chk(input logic [18:0] a, input logic [7:0] d);
    int lat, ev;
    logic [7:0] rd_before;
    ev = wr_events;
    rd_before = rsp_rdata;
    do_op(1'b1, a, d, lat);
    chk(lat == N_WR + 2, "R4 latency", lat, N_WR + 2);
    @(negedge clk);
    chk(!rsp_done, "R9 pulse", rsp_done, 0);
    chk(wr_events == ev + 1, "R4 one strobe", wr_events, ev + 1);
    chk(last_waddr == a, "R2 captured addr", int'(last_waddr), int'(a));
    chk(last_wdata == d, "R4 data", last_wdata, d);
    chk(last_wl == N_WR, "R4 pulse width", last_wl, N_WR);
    chk(rsp_rdata == rd_before, "R9 rdata kept", rsp_rdata, rd_before);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n == 1'b1, "R1 ce_n", mem_ce_n, 1);
    chk(mem_we_n == 1'b1, "R1 we_n", mem_we_n, 1);
    chk(mem_oe_n == 1'b1, "R1 oe_n", mem_oe_n, 1);
    chk(mem_dq_oe == 1'b0, "R1 dq_oe", mem_dq_oe, 0);
    chk(rsp_done == 1'b0 && rsp_rdata == 8'h00, "R1 outputs", rsp_rdata, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready idle", req_ready, 1);

    // R3: walking-one and boundary addresses
    for (int i = 0; i < 19; i++) rd_chk(19'(1) << i, "walk");
    rd_chk(19'h00000, "low");
    rd_chk(19'h7FFFF, "high");

    // R4: every data value
    for (int i = 0; i < 256; i++) wr_chk(19'(i * 2053 + 17), 8'(i));

    // R6, R8: alternating accesses
    for (int i = 0; i < 40; i++) begin
      if (i % 2 == 0) rd_chk(19'(i * 40503 + 7), "mix");
      else            wr_chk(19'(i * 40503 + 7), 8'(i * 37 + 1));
    end

    // R1: reset in the middle of a read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h12345;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 mid-access strobes", mem_ce_n, 1);
    chk(!mem_dq_oe, "R1 mid-access dq_oe", mem_dq_oe, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1 recover ready", req_ready, 1);
    rd_chk(19'h2AAAA, "after reset");
    wr_chk(19'h15555, 8'hC3);

    // Bus rule summaries
    chk(v_cont == 0, "R5 contention", v_cont, 0);
    chk(v_turn == 0, "R6 turnaround", v_turn, 0);
    chk(v_addr == 0, "R7 address", v_addr, 0);
    chk(v_data == 0, "R7 data", v_data, 0);
    chk(v_wr == 0, "R4 write strobes", v_wr, 0);
    chk(min_gap >= N_CYC, "R8 cycle spacing", min_gap, N_CYC);
    chk(v_gap == 0, "R8 write gap", v_gap, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    wait (cyc >= LIMIT);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule